// File: doc/BRIEF.md
# Bit-Level Serial EEPROM Responder

This block is a simplified two-wire serial EEPROM target that is driven entirely by sampled clock and data levels. A host that bit-bangs the bus hands over a new pair of levels with a one-cycle write strobe. The responder compares each pair with the pair it stored before and classifies the change. A change can be a bus condition (a START or a STOP), a clock rising edge that carries a data bit, or a change it ignores.

After a START, the responder collects an 8-bit command byte and then an 8-bit word address, both MSB first. It inserts an acknowledge slot after each byte. When the last command bit was 1, it shifts out its data register MSB first on the eight address clocks. When the eighth address bit arrives, it loads the byte stored at that address into the data register, so the next read transaction returns it. The storage is read-only and is filled from a parameter image. The data level that can be read back is always the last level stored, including any level the responder forced.

Top module: `bitbang_eeprom_responder`

## Requirements
- R1: After reset the responder is idle: bit counter 0, no acknowledge pending, stored clock and data levels both 1, data register 0, so `sda_out` reads 1.
- R2: A strobe where the clock is high before and after and the data level falls is a START. It sets the bit counter to 1 and clears the command byte. This also applies in the middle of a command byte, where the count starts over.
- R3: While the bit counter is 0 and no acknowledge is pending, every strobe other than a START leaves the state unchanged. `sda_out` then simply follows the host's data level and no acknowledge is ever driven.
- R4: A data bit is taken only on a clock rising edge (clock 0 before, 1 after) where the data level is unchanged. A rising edge that also changes the data level is not counted, and `sda_out` shows the new host level.
- R5: After 8 counted command bits an acknowledge is pending. The next clock rising edge stores data level 0 whatever the host drives, and that clears the pending acknowledge.
- R6: The 8 counted bits after the command acknowledge form the word address, MSB first. If bit 0 of the command (the last command bit sent) is 1, each of these edges stores the data register's bit 7 as the data level, and the register then shifts left by one.
- R7: On the 8th address bit the byte at that address is loaded into the data register, an acknowledge becomes pending and the counter returns to 0. The next rising edge stores level 0, and the responder is idle after that.
- R8: With command bit 0 equal to 0, `sda_out` follows the host level on the address edges, and the addressed byte is still fetched.
- R9: By default, the byte at address a is ((29*a + 7) mod 256) XOR (a with its two 4-bit halves swapped).
- R10: `sda_out` is registered. It changes only in the cycle after a write strobe and holds its value while no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle strobe: new line levels are presented |
| scl_in | input | 1 | Sampled clock level carried by the strobe |
| sda_in | input | 1 | Sampled data level carried by the strobe |
| sda_out | output | 1 | Last stored data level, including any forced level |

## Verification
A wrong bit counter moves the acknowledge slot. The error then appears as a 0 on `sda_out` at a clock edge where the host drives 1, within one byte of the fault. A lost or extra acknowledge flag either leaves the ack edge high or forces a later edge low. A wrong data register or fetch address corrupts the data bits of the following read, so an address-decode fault appears one transaction late. The address sweep carries each fetched byte into the next transaction so that this case is observed.

// File: rtl/eeprom_resp_pkg.sv
package eeprom_resp_pkg;

  localparam int BYTE_W    = 8;
  localparam int MAX_DEPTH = 256;
  localparam int IMG_W     = MAX_DEPTH * BYTE_W;
  localparam int TICK_W    = 5;
  localparam int ADDR_FIRST_TICK = BYTE_W + 1;       // first address bit
  localparam int FETCH_TICK      = 2 * BYTE_W;       // last address bit

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic same;
  } line_ev_t;

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] v,
                                                  input logic b);
    return {v[BYTE_W-2:0], b};
  endfunction

  function automatic logic [BYTE_W-1:0] seed_byte(input int unsigned a);
    logic [BYTE_W-1:0] x;
    x = a[BYTE_W-1:0];
    return (x * 8'd29 + 8'd7) ^ {x[3:0], x[7:4]};
  endfunction

  function automatic logic [IMG_W-1:0] default_image();
    logic [IMG_W-1:0] img;
    img = '0;
    for (int i = 0; i < MAX_DEPTH; i++) img[i*BYTE_W +: BYTE_W] = seed_byte(i);
    return img;
  endfunction

endpackage

// File: rtl/eeprom_line_watch.sv
module eeprom_line_watch
  import eeprom_resp_pkg::*;
(
  input  logic     scl_prev,
  input  logic     sda_prev,
  input  logic     scl_now,
  input  logic     sda_now,
  output line_ev_t ev
);
  always_comb begin
    ev.start = scl_prev & scl_now & sda_prev & ~sda_now;
    ev.stop  = scl_prev & scl_now & ~sda_prev & sda_now;
    ev.rise  = ~scl_prev & scl_now;
    ev.same  = (sda_prev == sda_now);
  end
endmodule

// File: rtl/eeprom_bit_seq.sv
module eeprom_bit_seq
  import eeprom_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  line_ev_t          ev,
  input  logic              bit_in,
  output logic              ack_slot,
  output logic              addr_take,
  output logic              fetch,
  output logic              cmd_read,
  output logic [BYTE_W-1:0] addr_next
);
  logic [TICK_W-1:0] tick;
  logic              ack_pend;
  logic [BYTE_W-1:0] cmd;
  logic [BYTE_W-1:0] addr;
  logic              bus_cond, idle, act, bit_take, cmd_take;

  always_comb begin
    bus_cond  = ev.start | ev.stop;
    idle      = (tick == '0) && !ack_pend;
    act       = wr_en && !bus_cond && !idle && ev.rise;
    ack_slot  = act && ack_pend;
    bit_take  = act && !ack_pend && ev.same;
    cmd_take  = bit_take && (tick < TICK_W'(ADDR_FIRST_TICK));
    addr_take = bit_take && (tick >= TICK_W'(ADDR_FIRST_TICK));
    fetch     = addr_take && (tick == TICK_W'(FETCH_TICK));
    addr_next = shift_in(addr, bit_in);
    cmd_read  = cmd[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick     <= '0;
      ack_pend <= 1'b0;
      cmd      <= '0;
      addr     <= '0;
    end else if (wr_en && ev.start) begin
      tick <= TICK_W'(1);
      cmd  <= '0;
    end else if (ack_slot) begin
      ack_pend <= 1'b0;
    end else if (cmd_take) begin
      cmd  <= shift_in(cmd, bit_in);
      tick <= tick + TICK_W'(1);
      if (tick == TICK_W'(BYTE_W)) ack_pend <= 1'b1;
    end else if (addr_take) begin
      addr <= addr_next;
      if (fetch) begin
        tick     <= '0;
        ack_pend <= 1'b1;
      end else begin
        tick <= tick + TICK_W'(1);
      end
    end
  end

  // R2
  start_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ev.start) |=> (tick == TICK_W'(1)) && (cmd == '0));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idle && !ev.start) |=> (tick == '0) && !ack_pend);
  // R4
  glitch_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ev.rise && !ev.same && !ack_pend) |=> $stable(tick));
  // R5
  cmd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && tick == TICK_W'(BYTE_W)) |=> ack_pend && (tick == TICK_W'(ADDR_FIRST_TICK)));
  // R6
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= TICK_W'(FETCH_TICK));
  // R7
  fetch_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> ack_pend && (tick == '0));
endmodule

// File: rtl/eeprom_byte_src.sv
module eeprom_byte_src
  import eeprom_resp_pkg::*;
#(
  parameter int               DEPTH = 256,
  parameter logic [IMG_W-1:0] INIT  = default_image()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              fetch,
  input  logic [BYTE_W-1:0] addr_next,
  output logic              msb
);
  localparam int AW = $clog2(DEPTH);

  logic [BYTE_W-1:0] data;
  logic [BYTE_W-1:0] rom_byte;

  function automatic logic [BYTE_W-1:0] lookup(input logic [AW-1:0] idx);
    return INIT[int'(idx)*BYTE_W +: BYTE_W];
  endfunction

  assign rom_byte = lookup(addr_next[AW-1:0]);
  assign msb      = data[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     data <= '0;
    else if (fetch) data <= rom_byte;
    else if (shift) data <= {data[BYTE_W-2:0], 1'b0};
  end

  // R6
  shift_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !fetch) |=> msb == $past(data[BYTE_W-2]));
  // R9
  fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> data == $past(rom_byte));
endmodule

// File: rtl/bitbang_eeprom_responder.sv
module bitbang_eeprom_responder
  import eeprom_resp_pkg::*;
#(
  parameter int               DEPTH = 256,
  parameter logic [IMG_W-1:0] INIT  = default_image()
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out
);
  logic     scl_q, sda_q, sda_next;
  line_ev_t ev;
  logic     ack_slot, addr_take, fetch, cmd_read, data_msb;
  logic [BYTE_W-1:0] addr_next;

  eeprom_line_watch u_watch (
    .scl_prev(scl_q), .sda_prev(sda_q), .scl_now(scl_in), .sda_now(sda_in), .ev(ev)
  );

  eeprom_bit_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ev(ev), .bit_in(sda_in),
    .ack_slot(ack_slot), .addr_take(addr_take), .fetch(fetch),
    .cmd_read(cmd_read), .addr_next(addr_next)
  );

  eeprom_byte_src #(.DEPTH(DEPTH), .INIT(INIT)) u_src (
    .clk(clk), .rst_n(rst_n), .shift(addr_take), .fetch(fetch),
    .addr_next(addr_next), .msb(data_msb)
  );

  always_comb begin
    if (ack_slot)                   sda_next = 1'b0;
    else if (addr_take && cmd_read) sda_next = data_msb;
    else                            sda_next = sda_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else if (wr_en) begin
      scl_q <= scl_in;
      sda_q <= sda_next;
    end
  end

  assign sda_out = sda_q;

  // R5
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_slot |=> !sda_out);
  // R8
  write_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_take && !cmd_read) |=> sda_out == $past(sda_in));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sda_out));
endmodule

// File: tb/test_bitbang_eeprom_responder.sv
`timescale 1ns/1ps
module test_bitbang_eeprom_responder;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
  logic sda_out;
  int checks = 0, errors = 0;
  logic [7:0] prev_data = 8'h00;
  bit done = 0;

  always #2 clk = ~clk;

  bitbang_eeprom_responder i_bitbang_eeprom_responder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .scl_in(scl_in), .sda_in(sda_in),
    .sda_out(sda_out)
  );

  function automatic logic [7:0] ref_byte(int a);
    int v, sw;
    v  = (a * 29 + 7) % 256;
    sw = (a % 16) * 16 + (a / 16);
    return 8'(v ^ sw);
  endfunction

  task automatic chk(bit ok, string req, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic ev(bit c, bit d);
    @(negedge clk);
    wr_en = 1'b1; scl_in = c; sda_in = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clk_bit(bit b, output bit got);
    ev(1'b0, b);
    ev(1'b1, b);
    got = sda_out;
  endtask

  task automatic start_cond();
    ev(1'b0, 1'b1); ev(1'b1, 1'b1); ev(1'b1, 1'b0); ev(1'b0, 1'b0);
  endtask

  task automatic stop_cond();
    ev(1'b0, 1'b0); ev(1'b1, 1'b0); ev(1'b1, 1'b1);
  endtask

  task automatic txn(logic [7:0] cmd, logic [7:0] a, int glitch_at, int restart_at);
    bit g;
    bit e;
    start_cond();
    if (restart_at >= 0) begin
      for (int i = 0; i < restart_at; i++) clk_bit(cmd[7-i], g);
      start_cond();  // R2: count starts over
    end
    for (int i = 0; i < 8; i++) begin
      if (i == glitch_at) begin
        ev(1'b0, 1'b0); ev(1'b1, 1'b1);
        chk(sda_out == 1'b1, "R4 glitch level", sda_out, 1);
      end
      clk_bit(cmd[7-i], g);
      chk(g == cmd[7-i], "R4 command bit", g, cmd[7-i]);
    end
    clk_bit(1'b1, g);
    chk(g == 1'b0, "R5 command ack", g, 0);
    for (int i = 0; i < 8; i++) begin
      clk_bit(a[7-i], g);
      if (cmd[0]) begin
        e = prev_data[7-i];
        chk(g == e, "R6 read bit", g, e);
      end else begin
        e = a[7-i];
        chk(g == e, "R8 write follow", g, e);
      end
    end
    clk_bit(1'b1, g);
    chk(g == 1'b0, "R7 address ack", g, 0);
    clk_bit(1'b1, g);
    chk(g == 1'b1, "R3 idle after frame", g, 1);
    stop_cond();
    prev_data = ref_byte(int'(a));  // R9
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog expired got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit g;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sda_out == 1'b1, "R1 reset level", sda_out, 1);
    // R10: no strobe, no change
    sda_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(sda_out == 1'b1, "R10 hold without strobe", sda_out, 1);
    // R3: idle ignores bits
    clk_bit(1'b0, g);
    chk(g == 1'b0, "R3 idle follows host", g, 0);
    for (int i = 0; i < 10; i++) begin
      clk_bit(1'b1, g);
      chk(g == 1'b1, "R3 idle no ack", g, 1);
    end
    for (int a = 0; a < 256; a++) begin
      logic [7:0] cmd;
      int gl, rs;
      cmd = (a % 16 == 5) ? 8'hA0 : 8'hA1;
      gl  = (a % 7 == 3) ? (a % 8) : -1;
      rs  = (a % 11 == 4) ? (a % 6) : -1;
      txn(cmd, 8'(a), gl, rs);
    end
    // final read returns last fetched byte (R9)
    txn(8'hA1, 8'h00, -1, -1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule